// File: doc/BRIEF.md
# Windowed Framed Serial Input Receiver

This block takes a compressed bitstream that an outside source pushes in on its own serial clock (at most 768 kHz), together with three side lines: a window that marks which bit periods carry valid data, an error flag that marks bits the source considers unreliable, and a frame-sync line whose rising edge announces the start of a frame. All four serial lines and the serial clock are brought into the much faster system clock domain through a synchroniser chain, and each line is sampled on the detected rising edge of the serial clock.

Valid bits are packed into bytes, earliest bit in the most significant position. Each completed byte leaves the block as a one-cycle strobe carrying the byte, the OR of the error flags of its valid bits, and a marker that is set on the first byte of a frame. A frame start throws away any partial byte, so the first frame bit always opens a new byte. Where the sync edge falls outside the window, the frame start is held until the window reopens. Frame parsing and CRC checking belong to the next stage.

Top module: `serial_frame_rx`

## Requirements
- R1: While `rst_n` is low at a system clock edge, and after it, `byte_valid`, `byte_data`, `byte_err` and `byte_first` are 0 and any partly assembled byte is dropped.
- R2: Each serial bit is taken once, on a rising edge of `ser_clk`; a bit whose `ser_win` sample is 0 is discarded and never enters a byte.
- R3: Bytes are formed MSB first: the first valid bit of a byte appears on `byte_data[7]`, the eighth on `byte_data[0]`.
- R4: `byte_err` is 1 exactly when at least one of the eight valid bits that formed the byte had `ser_err` sampled 1.
- R5: A `ser_err` value sampled with `ser_win` at 0 has no effect on any byte.
- R6: A frame start is recognised only where `ser_sync` is sampled 1 after having been sampled 0 on the previous serial edge (or after reset); holding it high does not start further frames.
- R7: When the frame start is sampled with `ser_win` at 1, that same bit is bit 7 of a new byte, and any partial byte before it is dropped.
- R8: When the frame start is sampled with `ser_win` at 0, the first bit later sampled with `ser_win` at 1 is bit 7 of a new byte.
- R9: `byte_first` is 1 on the first byte emitted after a frame start and 0 on every other byte.
- R10: `byte_valid` is a single system clock cycle pulse per byte, and `byte_data`, `byte_err`, `byte_first` are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than `ser_clk` |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock from the source, asynchronous to `clk` |
| ser_data | input | 1 | Serial data bit |
| ser_win | input | 1 | Window: 1 marks a valid bit |
| ser_err | input | 1 | Error flag for the current bit |
| ser_sync | input | 1 | Frame sync, rising edge marks frame start |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |
| byte_data | output | 8 | Assembled byte, first bit in MSB |
| byte_err | output | 1 | OR of error flags of the byte's valid bits |
| byte_first | output | 1 | Set on the first byte of a frame |

## Verification
The main stream mixes a frame start inside the window, a sync line held high for several bits, window gaps filled with set data and error bits, a single flagged bit inside a byte, a frame start during a closed window, and a frame start in mid-byte after five stray bits. The gaps separate a receiver that gates by the window from one that does not, the held sync separates edge from level detection, and the two frame-start placements separate the in-window rule from the deferred rule and show that partial bytes are dropped. A reset in mid-byte followed by a plain byte shows that reset clears the assembly state.

// File: rtl/sfr_pkg.sv
// Shared types for the windowed framed serial receiver.
package sfr_pkg;
    // One serial bit period as seen after sampling.
    typedef struct packed {
        logic data;
        logic win;
        logic err;
        logic sync;
    } ser_bit_t;
endpackage

// File: rtl/sfr_sync.sv
// Multi-bit synchroniser chain. Assumes each bit may be sampled
// independently; all bits get the same latency of STAGES cycles.
module sfr_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    // Shift the inputs down the flip-flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sfr_sampler.sv
// Brings the serial clock and its four companion lines into the system
// clock domain and produces one strobe per serial rising edge together
// with the values of the lines at that edge. Assumes the source changes
// its lines away from the serial rising edge and that the serial clock
// stays at each level for at least two system clock cycles.
module sfr_sampler
    import sfr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ser_clk,
    input  ser_bit_t raw_bit,
    output logic     smp_stb,
    output ser_bit_t smp_bit
);
    localparam int LINES = $bits(ser_bit_t) + 1;

    logic [LINES-1:0] synced;
    logic             clk_prev;

    sfr_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_clk, raw_bit}),
        .q     (synced)
    );

    // Detect the serial rising edge and capture the lines at it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_prev <= 1'b0;
            smp_stb  <= 1'b0;
            smp_bit  <= '0;
        end else begin
            clk_prev <= synced[LINES-1];
            smp_stb  <= synced[LINES-1] & ~clk_prev;
            smp_bit  <= synced[LINES-2:0];
        end
    end

    // R2
    // strobe_gap_chk: one sample per serial edge, never two in a row
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> !smp_stb);
endmodule

// File: rtl/sfr_assembler.sv
// Packs windowed serial bits into bytes, MSB first, with an OR'ed error
// flag and a first-of-frame marker. A frame start is the rising edge of
// the sampled sync line; it takes effect on the first bit inside the
// window at or after the edge and drops any partial byte.
module sfr_assembler
    import sfr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_stb,
    input  ser_bit_t          smp_bit,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_err,
    output logic              out_first
);
    localparam int CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] acc;
    logic              err_acc;
    logic              first_acc;
    logic              pending;
    logic              sync_prev;

    logic              sync_rise;
    logic              starting;
    logic [CNT_W-1:0]  bit_pos;
    logic [BYTE_W-1:0] nxt_acc;
    logic              nxt_err;
    logic              nxt_first;

    // Work out where the current bit lands and the resulting byte state.
    always_comb begin
        sync_rise = smp_bit.sync & ~sync_prev;
        starting  = smp_stb & smp_bit.win & (pending | sync_rise);
        bit_pos   = starting ? '0 : cnt;
        nxt_acc   = starting ? {{(BYTE_W-1){1'b0}}, smp_bit.data}
                             : {acc[BYTE_W-2:0], smp_bit.data};
        nxt_err   = (starting ? 1'b0 : err_acc) | smp_bit.err;
        nxt_first = starting | first_acc;
    end

    // Update assembly state on each sample and emit full bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            acc       <= '0;
            err_acc   <= 1'b0;
            first_acc <= 1'b0;
            pending   <= 1'b0;
            sync_prev <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_err   <= 1'b0;
            out_first <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (smp_stb) begin
                sync_prev <= smp_bit.sync;
                if (smp_bit.win) begin
                    pending <= 1'b0;
                    if (bit_pos == LAST_POS) begin
                        out_valid <= 1'b1;
                        out_data  <= nxt_acc;
                        out_err   <= nxt_err;
                        out_first <= nxt_first;
                        cnt       <= '0;
                        acc       <= '0;
                        err_acc   <= 1'b0;
                        first_acc <= 1'b0;
                    end else begin
                        cnt       <= bit_pos + CNT_W'(1);
                        acc       <= nxt_acc;
                        err_acc   <= nxt_err;
                        first_acc <= nxt_first;
                    end
                end else if (sync_rise) begin
                    pending <= 1'b1;
                end
            end
        end
    end

    // R5
    // win_gate_chk: a bit outside the window leaves byte state alone
    win_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && !smp_bit.win) |=> ($stable(cnt) && $stable(err_acc) && !out_valid));

    // R7
    // frame_align_chk: a frame-starting bit is always bit position zero
    frame_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        starting |=> (cnt == CNT_W'(1)));

    // R10
    // single_pulse_chk: byte strobe lasts one cycle
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R2
    // out_src_chk: a byte only follows a sample inside the window
    out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(smp_stb && smp_bit.win));
endmodule

// File: rtl/serial_frame_rx.sv
// Top of the windowed framed serial receiver: synchronising sampler
// followed by the byte assembler. Assumes the system clock runs at least
// four times faster than the serial clock.
module serial_frame_rx
    import sfr_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_win,
    input  logic              ser_err,
    input  logic              ser_sync,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_err,
    output logic              byte_first
);
    ser_bit_t raw_bit;
    ser_bit_t smp_bit;
    logic     smp_stb;

    assign raw_bit = '{data: ser_data, win: ser_win, err: ser_err, sync: ser_sync};

    sfr_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_clk (ser_clk),
        .raw_bit (raw_bit),
        .smp_stb (smp_stb),
        .smp_bit (smp_bit)
    );

    sfr_assembler #(.BYTE_W(BYTE_W)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_stb   (smp_stb),
        .smp_bit   (smp_bit),
        .out_valid (byte_valid),
        .out_data  (byte_data),
        .out_err   (byte_err),
        .out_first (byte_first)
    );
endmodule

// File: tb/sim_serial_frame_rx.sv
module sim_serial_frame_rx;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 45;
    localparam int NEXP = 4;

    // Serial bit vectors {data, win, err, sync}
    localparam logic [3:0] VEC [NVEC] = '{
        // frame start inside window, sync held 3 bits, gap with junk: A5
        4'b1101, 4'b0101, 4'b1101, 4'b0100, 4'b1010, 4'b1010,
        4'b0100, 4'b1100, 4'b0100, 4'b1100,
        // 3C with one flagged bit
        4'b0100, 4'b0100, 4'b1100, 4'b1110, 4'b1100, 4'b1100, 4'b0100, 4'b0100,
        // partial byte, sync edge with window closed, then F0
        4'b1100, 4'b1100, 4'b1100, 4'b0000, 4'b0001, 4'b1001,
        4'b1101, 4'b1100, 4'b1100, 4'b1100, 4'b0100, 4'b0100, 4'b0100, 4'b0100,
        // five stray bits, sync edge inside window mid-byte, then 81
        4'b1100, 4'b1100, 4'b1100, 4'b1100, 4'b1100,
        4'b1101, 4'b0100, 4'b0100, 4'b0100, 4'b0100, 4'b0100, 4'b0100, 4'b1100
    };
    // Expected bytes {first, err, data}
    localparam logic [9:0] EXP [NEXP] = '{
        {2'b10, 8'hA5}, {2'b01, 8'h3C}, {2'b10, 8'hF0}, {2'b10, 8'h81}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_win = 1'b0;
    logic       ser_err = 1'b0;
    logic       ser_sync = 1'b0;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       byte_err;
    logic       byte_first;

    int checks = 0;
    int failures = 0;
    logic [9:0] got [16];
    int got_n = 0;
    int run = 0;
    int max_run = 0;

    serial_frame_rx u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_win(ser_win), .ser_err(ser_err), .ser_sync(ser_sync),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_err(byte_err), .byte_first(byte_first)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Collect emitted bytes away from the active edge.
    always @(negedge clk) begin
        if (rst_n && byte_valid) begin
            if (got_n < 16) got[got_n] = {byte_first, byte_err, byte_data};
            got_n++;
            run++;
            if (run > max_run) max_run = run;
        end else begin
            run = 0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic [3:0] v);
        @(negedge clk);
        {ser_data, ser_win, ser_err, ser_sync} = v;
        ser_clk = 1'b0;
        repeat (4) @(negedge clk);
        ser_clk = 1'b1;
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs idle during reset
        check("R1 valid in reset", 32'(byte_valid), 0);
        check("R1 data in reset", 32'(byte_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 err/first after reset", 32'({byte_err, byte_first}), 0);

        // Main stream walked from the table
        for (int i = 0; i < NVEC; i++) send_bit(VEC[i]);
        repeat (10) @(negedge clk);

        check("R2 byte count", 32'(got_n), NEXP);
        check("R3 R6 R7 byte0", 32'(got[0]), 32'(EXP[0]));
        check("R4 R5 R9 byte1", 32'(got[1]), 32'(EXP[1]));
        check("R8 R6 byte2", 32'(got[2]), 32'(EXP[2]));
        check("R7 R9 byte3", 32'(got[3]), 32'(EXP[3]));
        check("R10 strobe width", 32'(max_run), 1);

        // R1: reset in mid-byte drops the partial byte
        got_n = 0;
        send_bit(4'b1100);
        send_bit(4'b1100);
        send_bit(4'b1100);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 valid in mid reset", 32'(byte_valid), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++)
            send_bit({(8'h5A >> (7 - i)) & 8'h01 ? 1'b1 : 1'b0, 3'b100});
        repeat (10) @(negedge clk);
        check("R1 count after mid reset", 32'(got_n), 1);
        check("R1 R9 byte after mid reset", 32'(got[0]), 32'({2'b00, 8'h5A}));
        check("R10 strobe width final", 32'(max_run), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule